// File: doc/BRIEF.md
# Packed Small-Float SIMD Arithmetic Unit

This unit performs floating-point arithmetic on narrow float formats packed into a 32-bit word. One instruction applies the same operation to every lane of the word. A format select picks between two lanes of a 16-bit float and four lanes of an 8-bit float. The 16-bit float has an 8-bit exponent, so it covers about the same range as single precision but keeps fewer mantissa bits. Each lane is computed on its own, and no carry or state passes between lanes.

The unit offers five operations: add, subtract, multiply, less-than and absolute value. All arithmetic rounds toward zero, and no other rounding mode exists. Add, subtract and multiply take two cycles. Compare and absolute value take one cycle. The unit holds its last result on the output until a later operation finishes. It takes no new operation while a two-cycle operation is in progress, so the issuer schedules around that latency.

Top module: `sfu_simd_top`

## Requirements
- R1: With `fmt_i`=0 the word holds two 16-bit lanes laid out as sign[15], exponent[14:7] (bias 127) and mantissa[6:0]. With `fmt_i`=1 it holds four 8-bit lanes laid out as sign[7], exponent[6:2] (bias 15) and mantissa[1:0]. Lane 0 sits in the lowest bits, and each lane is computed independently of the others.
- R2: Opcode 0 adds and opcode 1 subtracts (a − b). The result is the exact value truncated toward zero. Two zeros of the same sign give that signed zero. An exact cancellation gives +0.
- R3: Opcode 2 multiplies. The exact product is truncated toward zero, and a zero result carries the XOR of the operand signs.
- R4: An input with a zero exponent field counts as a signed zero. A nonzero result whose magnitude falls below the smallest normal value becomes a zero with the sign of the exact result.
- R5: A result whose magnitude reaches 2^(exponent max − bias) or more becomes infinity with the result's sign. Infinite operands propagate with the usual sign rules.
- R6: A NaN input produces the canonical quiet NaN, which has sign 0, an all-ones exponent and only the top mantissa bit set (0x7FC0 for 16-bit lanes, 0x7E for 8-bit lanes). So do inf − inf and 0 × inf.
- R7: Opcode 3 (less-than) writes all ones to a lane when a < b and all zeros otherwise. A NaN operand gives false, and +0 and −0 compare equal.
- R8: Opcode 4 (absolute value) clears each lane's sign bit and passes every other bit of operand a through unchanged, including a NaN payload.
- R9: When add, subtract or multiply is accepted, `res_valid_o` is low one cycle later and high, with the result, two cycles later. When compare or absolute value is accepted, `res_valid_o` is high one cycle later. Each accepted operation raises `res_valid_o` for exactly one cycle.
- R10: If `op_valid_i` arrives in the cycle after an accepted two-cycle operation, it is ignored and produces no result.
- R11: `res_o` changes only in a cycle where `res_valid_o` is high, and otherwise keeps the last result.
- R12: Opcodes 5, 6 and 7 are ignored. They produce no valid pulse and leave `res_o` unchanged.
- R13: A synchronous active-high reset clears `res_o` to zero and `res_valid_o` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Issue strobe for one operation |
| fmt_i | input | 1 | Lane format: 0 selects two 16-bit lanes, 1 selects four 8-bit lanes |
| opcode_i | input | 3 | 0 add, 1 sub, 2 mul, 3 less-than, 4 abs |
| src_a_i | input | 32 | Packed operand a |
| src_b_i | input | 32 | Packed operand b |
| res_valid_o | output | 1 | One-cycle pulse when a result is written |
| res_o | output | 32 | Packed result, held between pulses |

## Verification
The assertions check the control behaviour on every cycle. They cover the one-cycle and two-cycle latencies, the one-cycle busy window that blocks a second issue, the rejection of unused opcodes, and the rule that the result only changes together with a valid pulse. Lane arithmetic can only be shown by the bench's scenarios, which compare against a reference model built on real numbers. Those scenarios cover truncation toward zero, flush of small inputs and results, saturation to infinity, canonical NaN, the signs of zero results, and lane independence in both formats.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_LT  = 3'd3,
    OP_ABS = 3'd4
  } sfu_op_e;

  localparam int ARITH_LAT = 2;

  function automatic logic op_known(logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_multi(logic [2:0] code);
    return code <= 3'd2;
  endfunction
endpackage

// File: rtl/sfu_lane.sv
module sfu_lane
  import sfu_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 7,
  localparam int W = 1 + EW + MW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  sfu_op_e      op_i,
  output logic [W-1:0] res_o
);
  localparam int SW   = MW + 1;
  localparam int XW   = SW + 3;
  localparam int EMAX = (1 << EW) - 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic          sa, sb_raw, sb;
  logic [EW-1:0] ea, eb;
  logic [MW-1:0] ma, mb;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  assign {sa, ea, ma}     = a_i;
  assign {sb_raw, eb, mb} = b_i;
  assign sb     = sb_raw ^ (op_i == OP_SUB);
  assign a_nan  = (&ea) & (|ma);
  assign b_nan  = (&eb) & (|mb);
  assign a_inf  = (&ea) & ~(|ma);
  assign b_inf  = (&eb) & ~(|mb);
  assign a_zero = ~(|ea);
  assign b_zero = ~(|eb);

  // add / subtract with guard, round and sticky bits, truncated
  logic [W-1:0]  add_r;
  logic          sl, ss;
  logic [EW-1:0] el, es;
  logic [MW-1:0] ml, ms;
  logic [XW-1:0] big_x, sm_full, sm_x, norm;
  logic [XW:0]   acc;
  int            dexp, ex, lz;
  logic          found;

  always_comb begin
    if ({eb, mb} > {ea, ma}) begin
      sl = sb; el = eb; ml = mb; ss = sa; es = ea; ms = ma;
    end else begin
      sl = sa; el = ea; ml = ma; ss = sb; es = eb; ms = mb;
    end
    dexp    = int'(el) - int'(es);
    big_x   = {1'b1, ml, 3'b000};
    sm_full = {1'b1, ms, 3'b000};
    if (dexp >= XW) sm_x = {{(XW-1){1'b0}}, 1'b1};
    else sm_x = (sm_full >> dexp) |
                {{(XW-1){1'b0}}, |(sm_full & ~({XW{1'b1}} << dexp))};
    if (sl == ss) acc = {1'b0, big_x} + {1'b0, sm_x};
    else          acc = {1'b0, big_x} - {1'b0, sm_x};
    lz = 0;
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found) begin
        if (acc[i]) found = 1'b1;
        else lz = lz + 1;
      end
    end
    ex = int'(el);
    if (acc[XW]) begin
      ex   = ex + 1;
      norm = acc[XW:1];
    end else begin
      ex   = ex - lz;
      norm = acc[XW-1:0] << lz;
    end
    if (a_nan | b_nan) add_r = QNAN;
    else if (a_inf & b_inf) add_r = (sa != sb) ? QNAN : {sa, {EW{1'b1}}, {MW{1'b0}}};
    else if (a_inf) add_r = {sa, {EW{1'b1}}, {MW{1'b0}}};
    else if (b_inf) add_r = {sb, {EW{1'b1}}, {MW{1'b0}}};
    else if (a_zero & b_zero) add_r = {sa & sb, {(W-1){1'b0}}};
    else if (a_zero) add_r = {sb, eb, mb};
    else if (b_zero) add_r = {sa, ea, ma};
    else if (acc == '0) add_r = '0;
    else if (ex >= EMAX) add_r = {sl, {EW{1'b1}}, {MW{1'b0}}};
    else if (ex < 1) add_r = {sl, {(W-1){1'b0}}};
    else add_r = {sl, EW'(ex), norm[XW-2 -: MW]};
  end

  // multiply, truncated
  logic [W-1:0]    mul_r;
  logic [2*SW-1:0] prod;
  logic [MW-1:0]   pm;
  logic            sp;
  int              pe;

  always_comb begin
    sp   = sa ^ sb_raw;
    prod = {1'b1, ma} * {1'b1, mb};
    pe   = int'(ea) + int'(eb) - BIAS;
    if (prod[2*SW-1]) begin
      pe = pe + 1;
      pm = prod[2*SW-2 -: MW];
    end else begin
      pm = prod[2*SW-3 -: MW];
    end
    if (a_nan | b_nan) mul_r = QNAN;
    else if ((a_inf & b_zero) | (b_inf & a_zero)) mul_r = QNAN;
    else if (a_inf | b_inf) mul_r = {sp, {EW{1'b1}}, {MW{1'b0}}};
    else if (a_zero | b_zero) mul_r = {sp, {(W-1){1'b0}}};
    else if (pe >= EMAX) mul_r = {sp, {EW{1'b1}}, {MW{1'b0}}};
    else if (pe < 1) mul_r = {sp, {(W-1){1'b0}}};
    else mul_r = {sp, EW'(pe), pm};
  end

  // ordered compare with flushed zeros
  logic [W-2:0] mag_a, mag_b;
  logic         neg_a, neg_b, lt;

  always_comb begin
    mag_a = a_zero ? '0 : {ea, ma};
    mag_b = b_zero ? '0 : {eb, mb};
    neg_a = sa & ~a_zero;
    neg_b = sb_raw & ~b_zero;
    if (a_nan | b_nan) lt = 1'b0;
    else if (neg_a != neg_b) lt = neg_a;
    else if (!neg_a) lt = mag_a < mag_b;
    else lt = mag_a > mag_b;
  end

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: res_o = add_r;
      OP_MUL:         res_o = mul_r;
      OP_LT:          res_o = {W{lt}};
      OP_ABS:         res_o = {1'b0, a_i[W-2:0]};
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/sfu_bank.sv
module sfu_bank
  import sfu_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 7,
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  sfu_op_e       op_i,
  output logic [DW-1:0] res_o
);
  localparam int LW = 1 + EW + MW;
  localparam int NL = DW / LW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    sfu_lane #(.EW(EW), .MW(MW)) u_lane (
      .a_i  (a_i[g*LW +: LW]),
      .b_i  (b_i[g*LW +: LW]),
      .op_i (op_i),
      .res_o(res_o[g*LW +: LW])
    );
  end
endmodule

// File: rtl/sfu_simd_top.sv
module sfu_simd_top
  import sfu_pkg::*;
#(
  parameter int DW   = 32,
  parameter int H_EW = 8,
  parameter int H_MW = 7,
  parameter int B_EW = 5,
  parameter int B_MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          op_valid_i,
  input  logic          fmt_i,
  input  logic [2:0]    opcode_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o
);
  logic          busy_q, hold_fmt_q;
  logic [2:0]    hold_op_q;
  logic [DW-1:0] hold_a_q, hold_b_q;
  logic [DW-1:0] cur_a, cur_b, half_res, byte_res, sel_res;
  logic          cur_fmt, take, take_arith, take_logic;
  sfu_op_e       cur_op;

  assign take       = op_valid_i & ~busy_q & op_known(opcode_i);
  assign take_arith = take & op_multi(opcode_i);
  assign take_logic = take & ~op_multi(opcode_i);

  assign cur_a   = busy_q ? hold_a_q : src_a_i;
  assign cur_b   = busy_q ? hold_b_q : src_b_i;
  assign cur_fmt = busy_q ? hold_fmt_q : fmt_i;
  assign cur_op  = sfu_op_e'(busy_q ? hold_op_q : opcode_i);

  sfu_bank #(.EW(H_EW), .MW(H_MW), .DW(DW)) u_half (
    .a_i(cur_a), .b_i(cur_b), .op_i(cur_op), .res_o(half_res)
  );
  sfu_bank #(.EW(B_EW), .MW(B_MW), .DW(DW)) u_byte (
    .a_i(cur_a), .b_i(cur_b), .op_i(cur_op), .res_o(byte_res)
  );

  assign sel_res = cur_fmt ? byte_res : half_res;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q      <= 1'b0;
      hold_fmt_q  <= 1'b0;
      hold_op_q   <= '0;
      hold_a_q    <= '0;
      hold_b_q    <= '0;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (busy_q) begin
        busy_q      <= 1'b0;
        res_o       <= sel_res;
        res_valid_o <= 1'b1;
      end else if (take_arith) begin
        busy_q     <= 1'b1;
        hold_a_q   <= src_a_i;
        hold_b_q   <= src_b_i;
        hold_fmt_q <= fmt_i;
        hold_op_q  <= opcode_i;
      end else if (take_logic) begin
        res_o       <= sel_res;
        res_valid_o <= 1'b1;
      end
    end
  end

  AST_ARITH_TWO_CYCLES: assert property (@(posedge clk_i) disable iff (rst_i)
    take_arith |=> !res_valid_o ##1 res_valid_o); // R9
  AST_LOGIC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    take_logic |=> res_valid_o); // R9
  AST_BUSY_ONE_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |=> !busy_q); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
    !res_valid_o |-> $stable(res_o)); // R11
  AST_UNUSED_OPCODE: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_valid_i && !busy_q && !op_known(opcode_i)) |=> !res_valid_o); // R12
endmodule

// File: tb/tb_sfu_simd_top.sv
module tb_sfu_simd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vin = 1'b0;
  logic        fmt = 1'b0;
  logic [2:0]  op  = 3'd0;
  logic [31:0] a   = '0;
  logic [31:0] b   = '0;
  logic        vout;
  logic [31:0] res;

  always #10 clk = ~clk;

  sfu_simd_top dut (
    .clk_i(clk), .rst_i(rst), .op_valid_i(vin), .fmt_i(fmt), .opcode_i(op),
    .src_a_i(a), .src_b_i(b), .res_valid_o(vout), .res_o(res)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    done   = 1'b0;
  string tag    = "R13";

  // ---------- behavioural reference on real numbers ----------
  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic void dec(input logic [15:0] x, input bit f8, output real v,
                              output bit nan, output bit inf, output bit zer,
                              output bit sg);
    int ew = f8 ? 5 : 8;
    int mw = f8 ? 2 : 7;
    int emax = (1 << ew) - 1;
    int bias = (1 << (ew - 1)) - 1;
    int e = (int'(x) >> mw) & emax;
    int m = int'(x) & ((1 << mw) - 1);
    sg  = x[ew + mw];
    nan = (e == emax) && (m != 0);
    inf = (e == emax) && (m == 0);
    zer = (e == 0);
    if (zer) v = 0.0;
    else if (inf) v = 1.0e300;
    else v = (1.0 + real'(m) / p2(mw)) * p2(e - bias);
    if (sg) v = -v;
  endfunction

  function automatic logic [15:0] enc(real r, bit zs, bit f8);
    int ew = f8 ? 5 : 8;
    int mw = f8 ? 2 : 7;
    int emax = (1 << ew) - 1;
    int bias = (1 << (ew - 1)) - 1;
    int sgn, e, m, w;
    real x, y;
    if (r == 0.0) begin
      w = int'(zs) << (ew + mw);
      return w[15:0];
    end
    sgn = (r < 0.0) ? 1 : 0;
    x = (r < 0.0) ? -r : r;
    if (x >= p2(emax - bias)) w = (sgn << (ew + mw)) | (emax << mw);
    else if (x < p2(1 - bias)) w = sgn << (ew + mw);
    else begin
      y = x / p2(1 - bias);
      e = 1;
      while (y >= 2.0) begin
        y = y / 2.0;
        e++;
      end
      m = $rtoi((y - 1.0) * p2(mw));
      w = (sgn << (ew + mw)) | (e << mw) | m;
    end
    return w[15:0];
  endfunction

  function automatic logic [15:0] ref_lane(bit f8, int opc, logic [15:0] x, logic [15:0] y);
    int ew = f8 ? 5 : 8;
    int mw = f8 ? 2 : 7;
    int emax = (1 << ew) - 1;
    int qn = (emax << mw) | (1 << (mw - 1));
    int infw = emax << mw;
    int sh = ew + mw;
    int w;
    real va, vb, r;
    bit an, ai, az, as_, bn, bi, bz, bs;
    dec(x, f8, va, an, ai, az, as_);
    dec(y, f8, vb, bn, bi, bz, bs);
    w = 0;
    case (opc)
      0, 1: begin
        if (opc == 1) begin bs = ~bs; vb = -vb; end
        if (an || bn) w = qn;
        else if (ai && bi) w = (as_ != bs) ? qn : ((int'(as_) << sh) | infw);
        else if (ai) w = (int'(as_) << sh) | infw;
        else if (bi) w = (int'(bs) << sh) | infw;
        else begin
          r = va + vb;
          w = int'(enc(r, (az && bz) ? (as_ & bs) : 1'b0, f8));
        end
      end
      2: begin
        if (an || bn) w = qn;
        else if ((ai && bz) || (bi && az)) w = qn;
        else if (ai || bi) w = (int'(as_ ^ bs) << sh) | infw;
        else w = int'(enc(va * vb, as_ ^ bs, f8));
      end
      3: w = (!an && !bn && (va < vb)) ? 16'hFFFF : 0;
      4: w = int'(x) & ~(1 << sh);
      default: w = 0;
    endcase
    return w[15:0];
  endfunction

  function automatic logic [31:0] ref_word(bit f8, int opc, logic [31:0] x, logic [31:0] y);
    int w = f8 ? 8 : 16;
    logic [31:0] mask = f8 ? 32'hFF : 32'hFFFF;
    logic [31:0] accw = '0;
    for (int l = 0; l < 32 / w; l++) begin
      logic [15:0] la, lb, lr;
      la = 16'((x >> (l * w)) & mask);
      lb = 16'((y >> (l * w)) & mask);
      lr = ref_lane(f8, opc, la, lb);
      accw = accw | ((32'(lr) & mask) << (l * w));
    end
    return accw;
  endfunction

  // ---------- cycle model ----------
  logic        m_vld  = 1'b0;
  logic [31:0] m_res  = '0;
  logic [31:0] m_pend = '0;
  int          m_wait = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_vld <= 1'b0;
      m_res <= '0;
      m_wait <= 0;
    end else begin
      m_vld <= 1'b0;
      if (m_wait > 0) begin
        m_wait <= m_wait - 1;
        if (m_wait == 1) begin
          m_res <= m_pend;
          m_vld <= 1'b1;
        end
      end else if (vin && op <= 3'd2) begin
        m_pend <= ref_word(fmt, int'(op), a, b);
        m_wait <= sfu_pkg::ARITH_LAT - 1;
      end else if (vin && (op == 3'd3 || op == 3'd4)) begin
        m_res <= ref_word(fmt, int'(op), a, b);
        m_vld <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (vout !== m_vld || res !== m_res) begin
        errors++;
        $display("FAIL %s cycle %0d: valid %0b result %h, expected valid %0b result %h",
                 tag, cyc, vout, res, m_vld, m_res);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------- helpers ----------
  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic issue(bit f, int o, logic [31:0] x, logic [31:0] y);
    fmt = f; op = 3'(o); a = x; b = y; vin = 1'b1;
    @(negedge clk);
    vin = 1'b0;
  endtask

  task automatic directed(string t, bit f, int o, logic [31:0] x, logic [31:0] y,
                          logic [31:0] exp);
    tag = t;
    issue(f, o, x, y);
    if (o <= 2) @(negedge clk);
    chk(t, {31'd0, vout}, 32'd1);
    chk(t, res, exp);
    @(negedge clk);
  endtask

  function automatic logic [15:0] gen_h();
    int k = int'($urandom % 16);
    int e = (k == 0) ? 0 : (k == 1) ? 255 : 110 + int'($urandom % 40);
    int w = (int'($urandom % 2) << 15) | (e << 7) | int'($urandom % 128);
    return w[15:0];
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0, 1: return "R2";
      2: return "R3";
      3: return "R7";
      4: return "R8";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", {31'd0, vout}, 32'd0);
    chk("R13", res, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: two 16-bit lanes computed apart: 1+2=3, 1+1=2
    directed("R1", 1'b0, 0, 32'h3F80_4000, 32'h3F80_3F80, 32'h4000_4040);
    // R2: 1.0 minus a tiny value truncates to just below 1.0; +0 - +0 = +0
    directed("R2", 1'b0, 1, 32'h0000_3F80, 32'h0000_3200, 32'h0000_3F7F);
    // R3: 1.25*1.25 = 1.5625 truncates to 1.5 in every 8-bit lane
    directed("R3", 1'b1, 2, 32'h3D3D_3D3D, 32'h3D3D_3D3D, 32'h3E3E_3E3E);
    // R4: denormal operand flushed, tiny difference flushed, cancellation gives +0
    directed("R4", 1'b1, 1, 32'h3C84_053C, 32'h3C05_0401, 32'h0088_003C);
    // R5: 2^100 * 2^100 saturates to signed infinity
    directed("R5", 1'b0, 2, 32'hF180_7180, 32'h7180_7180, 32'hFF80_7F80);
    // R6: NaN in, inf-inf, inf+1, signed NaN in
    directed("R6", 1'b1, 0, 32'hFF7C_7C7D, 32'h003C_FC3C, 32'h7E7C_7E7E);
    directed("R6", 1'b0, 2, 32'h7F80_7FA1, 32'h0000_3F80, 32'h7FC0_7FC0);
    // R7: -0 < +0 false, 1 < 2 true; NaN, sign and flushed-zero cases
    directed("R7", 1'b0, 3, 32'h3F80_8000, 32'h4000_0000, 32'hFFFF_0000);
    directed("R7", 1'b1, 3, 32'h013C_BC7D, 32'h02BC_3C3C, 32'h0000_FF00);
    // R8: sign bits cleared, payload kept
    directed("R8", 1'b1, 4, 32'hFF80_817F, 32'h1234_5678, 32'h7F00_017F);
    directed("R8", 1'b0, 4, 32'hFFC1_8001, 32'h0, 32'h7FC1_0001);

    // R9: latency of multiply then compare
    tag = "R9";
    issue(1'b0, 2, 32'h3F80_3F80, 32'h4000_4000);
    chk("R9", {31'd0, vout}, 32'd0);
    @(negedge clk);
    chk("R9", {31'd0, vout}, 32'd1);
    chk("R9", res, 32'h4000_4000);
    issue(1'b0, 3, 32'h3F80_4000, 32'h4000_3F80);
    chk("R9", {31'd0, vout}, 32'd1);
    chk("R9", res, 32'hFFFF_0000);
    @(negedge clk);
    chk("R9", {31'd0, vout}, 32'd0);

    // R10: issue in the busy cycle is dropped
    tag = "R10";
    fmt = 1'b0; op = 3'd0; a = 32'h3F80_3F80; b = 32'h3F80_4000; vin = 1'b1;
    @(negedge clk);
    op = 3'd4; a = 32'hFFFF_FFFF;
    @(negedge clk);
    vin = 1'b0;
    chk("R10", {31'd0, vout}, 32'd1);
    chk("R10", res, 32'h4000_4040);
    @(negedge clk);
    chk("R10", {31'd0, vout}, 32'd0);
    chk("R10", res, 32'h4000_4040);

    // R12: unused opcodes change nothing
    for (int o = 5; o < 8; o++) begin
      tag = "R12";
      issue(1'b1, o, 32'h1111_1111, 32'h2222_2222);
      chk("R12", {31'd0, vout}, 32'd0);
      chk("R12", res, 32'h4000_4040);
    end

    // R11: idle cycles hold the result
    tag = "R11";
    repeat (4) @(negedge clk);
    chk("R11", res, 32'h4000_4040);

    // random streams, back-to-back issues included
    for (int i = 0; i < 3000; i++) begin
      bit f = 1'($urandom % 2);
      int o = int'($urandom % 8);
      logic [31:0] x = f ? $urandom : {gen_h(), gen_h()};
      logic [31:0] y = f ? $urandom : {gen_h(), gen_h()};
      tag = tag_of(o);
      issue(f, o, x, y);
      if ($urandom % 2 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule